// File: doc/BRIEF.md
# Twelve-Bit Accumulator Processor Core

A multicycle processor core for a classic twelve-bit accumulator instruction set. It fetches words from a synchronous memory, decodes them, and executes two groups. The first group is the six memory-reference operations: logical AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, jump-to-subroutine and jump. The second group is the operate microinstructions, which clear, complement, increment, rotate, test and halt. Operands are reached directly on page zero or on the page of the current instruction. A word found on either of those pages can also serve as a full twelve-bit pointer.

The core drives a twelve-bit address, twelve-bit write data and a write strobe. It reads sixteen-bit words one cycle after it presents an address and uses only their low twelve bits. The program counter, instruction register, accumulator and link bit are visible for observation. A halted flag rises when a halt microinstruction executes. After that, the core stays frozen until reset. Input/output transfer instructions execute as no-operations.

Top module: `acc12_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the program counter, instruction register, accumulator and link are all zero and halted is low. The first fetch is from address 0.
- R2: In a memory-reference word, bits [11:9] are the opcode (0 AND, 1 add, 2 increment-skip, 3 deposit, 4 subroutine call, 5 jump, 6 I/O, 7 operate), bit 8 selects a pointer and bit 7 selects the current page. The target is {bit 7 ? PC[11:7] of the instruction : 0, bits [6:0]}.
- R3: With bit 8 set, the word at the target is read and used as the full twelve-bit address of the operand.
- R4: Add (opcode 1) sums the operand into the accumulator modulo 4096 and inverts the link on a carry out. AND (opcode 0) replaces the accumulator with the bitwise AND. A direct add takes exactly 3 clock cycles.
- R5: Increment-skip (opcode 2) writes the operand plus one back to memory. It skips the next word exactly when the new value is zero.
- R6: Deposit (opcode 3) writes the accumulator to memory and then clears it.
- R7: Subroutine call (opcode 4) writes the address of the next word to the target and continues at the target plus one. Jump (opcode 5) continues at the target. Through a pointer jump, calls return correctly when nested.
- R8: An operate word with bit 8 clear acts in this order: bit 7 clears AC and bit 6 clears the link; then bit 5 complements AC and bit 4 complements the link; then bit 0 increments the 13-bit {link, AC}; then the rotates.
- R9: The rotates act on the 13-bit {link, AC}. Bit 2 rotates left; bit 3 rotates right when bit 2 is clear. Bit 1 doubles the rotation that was selected, and it does nothing when no rotation is selected.
- R10: An operate word with bit 8 set and bit 0 clear forms a condition from the accumulator as it was before the word: bit 6 for AC negative, bit 5 for AC zero, bit 4 for link set, ORed together. The core skips when the condition differs from bit 3. Bit 7 then clears AC, and bit 2 is ignored.
- R11: An operate word with bit 8 set, bit 0 clear and bit 1 set (for example octal 7402) raises halted. After that, PC, AC and IR hold, no memory write occurs and halted stays high until reset.
- R12: The upper four bits of read data have no effect, and opcode 6 only advances PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 12 | Word address presented to memory |
| mem_wdata | output | 12 | Data to write |
| mem_we | output | 1 | Write strobe for mem_addr in this cycle |
| mem_rdata | input | 16 | Word read from the address of the previous cycle |
| pc_o | output | 12 | Program counter |
| ir_o | output | 12 | Instruction register |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| halted | output | 1 | High once a halt microinstruction has executed |

## Verification
The assertions check the halt rules on every cycle: halted stays high once set and is raised only by a halting operate word. While halted, PC and AC hold and no write is issued; reset leaves all registers cleared. The arithmetic is shown only by the bench's scenarios. These include the microinstruction ordering and rotates, the skip senses, carries into the link, page and pointer addressing, increment-skip loops, nested calls and the exact cycle count of an add. The bench sweeps every combination of the operate bits against several accumulator and link values.

// File: rtl/acc12_pkg.sv
package acc12_pkg;
  localparam int WORD_W   = 12;
  localparam int OFFS_W   = 7;
  localparam int PAGE_W   = WORD_W - OFFS_W;
  localparam int IND_BIT  = 8;
  localparam int PAGE_BIT = 7;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_TAD = 3'd1,
    OP_ISZ = 3'd2,
    OP_DCA = 3'd3,
    OP_JMS = 3'd4,
    OP_JMP = 3'd5,
    OP_IOT = 3'd6,
    OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_INDIR  = 3'd2,
    ST_EXEC   = 3'd3,
    ST_HALT   = 3'd4
  } state_e;
endpackage

// File: rtl/acc12_addr_gen.sv
module acc12_addr_gen
  import acc12_pkg::*;
(
  input  word_t instr,
  input  word_t pc,
  output word_t ea
);
  logic [PAGE_W-1:0] page_sel;

  assign page_sel = instr[PAGE_BIT] ? pc[WORD_W-1:OFFS_W] : '0;
  assign ea       = {page_sel, instr[OFFS_W-1:0]};
endmodule

// File: rtl/acc12_alu.sv
module acc12_alu
  import acc12_pkg::*;
(
  input  opcode_e op,
  input  word_t   ac,
  input  logic    link,
  input  word_t   opnd,
  output word_t   ac_n,
  output logic    link_n,
  output word_t   inc_val,
  output logic    inc_zero
);
  logic [WORD_W:0] sum;

  assign sum      = {1'b0, ac} + {1'b0, opnd};
  assign inc_val  = opnd + word_t'(1);
  assign inc_zero = (inc_val == '0);

  always_comb begin
    ac_n   = ac;
    link_n = link;
    case (op)
      OP_AND: ac_n = ac & opnd;
      OP_TAD: begin
        ac_n   = sum[WORD_W-1:0];
        link_n = link ^ sum[WORD_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc12_opr.sv
module acc12_opr
  import acc12_pkg::*;
(
  input  word_t instr,
  input  word_t ac,
  input  logic  link,
  output word_t ac_n,
  output logic  link_n,
  output logic  skip,
  output logic  halt
);
  logic [WORD_W:0] la;
  logic            cond;

  always_comb begin
    la   = {link, ac};
    skip = 1'b0;
    halt = 1'b0;
    cond = 1'b0;
    if (!instr[8]) begin
      if (instr[7]) la[WORD_W-1:0] = '0;
      if (instr[6]) la[WORD_W]     = 1'b0;
      if (instr[5]) la[WORD_W-1:0] = ~la[WORD_W-1:0];
      if (instr[4]) la[WORD_W]     = ~la[WORD_W];
      if (instr[0]) la = la + {{WORD_W{1'b0}}, 1'b1};
      for (int k = 0; k < 2; k++) begin
        if (k == 0 || instr[1]) begin
          if (instr[2])      la = {la[WORD_W-1:0], la[WORD_W]};
          else if (instr[3]) la = {la[0], la[WORD_W:1]};
        end
      end
    end else if (!instr[0]) begin
      cond = (instr[6] && ac[WORD_W-1]) ||
             (instr[5] && (ac == '0))   ||
             (instr[4] && link);
      skip = cond ^ instr[3];
      if (instr[7]) la[WORD_W-1:0] = '0;
      halt = instr[1];
    end else begin
      if (instr[7]) la[WORD_W-1:0] = '0;
    end
    ac_n   = la[WORD_W-1:0];
    link_n = la[WORD_W];
  end
endmodule

// File: rtl/acc12_core.sv
module acc12_core
  import acc12_pkg::*;
#(
  parameter int RDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               mem_we,
  input  logic [RDATA_W-1:0] mem_rdata,
  output logic [WORD_W-1:0]  pc_o,
  output logic [WORD_W-1:0]  ir_o,
  output logic [WORD_W-1:0]  ac_o,
  output logic               link_o,
  output logic               halted
);
  localparam int SPARE_W = RDATA_W - WORD_W;

  state_e state_q, state_d;
  word_t  pc_q, pc_d, ir_q, ir_d, ac_q, ac_d, ma_q, ma_d;
  logic   link_q, link_d;
  logic   ir_en;

  word_t   rword, cur_ir, ea_c, tgt, pc_ret;
  opcode_e opc;
  logic    do_ref;

  word_t   opr_ac, alu_ac, inc_val;
  logic    opr_link, opr_skip, opr_halt, alu_link, inc_zero;

  assign rword = mem_rdata[WORD_W-1:0];

  generate
    if (SPARE_W > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^mem_rdata[RDATA_W-1:WORD_W];
    end
  endgenerate

  assign cur_ir = (state_q == ST_DECODE) ? rword : ir_q;
  assign opc    = opcode_e'(cur_ir[WORD_W-1:WORD_W-3]);
  assign tgt    = (state_q == ST_INDIR) ? rword : ea_c;
  assign pc_ret = (state_q == ST_DECODE) ? pc_q + word_t'(1) : pc_q;

  acc12_addr_gen u_addr (
    .instr (rword),
    .pc    (pc_q),
    .ea    (ea_c)
  );

  acc12_opr u_opr (
    .instr  (rword),
    .ac     (ac_q),
    .link   (link_q),
    .ac_n   (opr_ac),
    .link_n (opr_link),
    .skip   (opr_skip),
    .halt   (opr_halt)
  );

  acc12_alu u_alu (
    .op       (opc),
    .ac       (ac_q),
    .link     (link_q),
    .opnd     (rword),
    .ac_n     (alu_ac),
    .link_n   (alu_link),
    .inc_val  (inc_val),
    .inc_zero (inc_zero)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    ir_en     = 1'b0;
    ac_d      = ac_q;
    link_d    = link_q;
    ma_d      = ma_q;
    mem_addr  = ma_q;
    mem_wdata = ac_q;
    mem_we    = 1'b0;
    do_ref    = 1'b0;

    case (state_q)
      ST_FETCH: begin
        mem_addr = pc_q;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d  = rword;
        ir_en = 1'b1;
        pc_d  = pc_q + word_t'(1);
        if (opc == OP_OPR) begin
          ac_d    = opr_ac;
          link_d  = opr_link;
          pc_d    = pc_q + (opr_skip ? word_t'(2) : word_t'(1));
          state_d = opr_halt ? ST_HALT : ST_FETCH;
        end else if (opc == OP_IOT) begin
          state_d = ST_FETCH;
        end else if (cur_ir[IND_BIT]) begin
          mem_addr = ea_c;
          ma_d     = ea_c;
          state_d  = ST_INDIR;
        end else begin
          do_ref = 1'b1;
        end
      end
      ST_INDIR: begin
        do_ref = 1'b1;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        if (opc == OP_ISZ) begin
          mem_we    = 1'b1;
          mem_wdata = inc_val;
          if (inc_zero) pc_d = pc_q + word_t'(1);
        end else begin
          ac_d   = alu_ac;
          link_d = alu_link;
        end
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase

    if (do_ref) begin
      mem_addr = tgt;
      ma_d     = tgt;
      state_d  = ST_FETCH;
      case (opc)
        OP_JMP: pc_d = tgt;
        OP_JMS: begin
          mem_we    = 1'b1;
          mem_wdata = pc_ret;
          pc_d      = tgt + word_t'(1);
        end
        OP_DCA: begin
          mem_we    = 1'b1;
          mem_wdata = ac_q;
          ac_d      = '0;
        end
        default: state_d = ST_EXEC;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ac_q    <= '0;
      link_q  <= 1'b0;
      ma_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ac_q    <= ac_d;
      link_q  <= link_d;
      ma_q    <= ma_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign pc_o   = pc_q;
  assign ir_o   = ir_q;
  assign ac_o   = ac_q;
  assign link_o = link_q;
  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc12_core_chk.sv
module acc12_core_chk
  import acc12_pkg::*;
#(
  parameter int RDATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  mem_addr,
  input logic [WORD_W-1:0]  mem_wdata,
  input logic               mem_we,
  input logic [RDATA_W-1:0] mem_rdata,
  input logic [WORD_W-1:0]  pc_o,
  input logic [WORD_W-1:0]  ir_o,
  input logic [WORD_W-1:0]  ac_o,
  input logic               link_o,
  input logic               halted
);
  logic unused_chk;
  assign unused_chk = ^{mem_addr, mem_wdata, mem_rdata};

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc_o == '0 && ir_o == '0 && ac_o == '0 && !link_o && !halted));

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r11_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc_o) && $stable(ac_o) && $stable(ir_o) && $stable(link_o)));

  a_r11_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  a_r11_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (ir_o[11:9] == 3'b111 && ir_o[8] && ir_o[1] && !ir_o[0]));
endmodule

bind acc12_core acc12_core_chk #(.RDATA_W(RDATA_W)) chk_i (.*);

// File: tb/acc12_core_tb_top.sv
module acc12_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, mem_wdata, pc_o, ir_o, ac_o;
  logic        mem_we, link_o, halted;
  logic [15:0] mem_rdata;
  logic [15:0] mem [4096];

  int checks = 0;
  int fails = 0;
  int we_halted = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc12_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_o(pc_o), .ir_o(ir_o),
    .ac_o(ac_o), .link_o(link_o), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= {4'h0, mem_wdata};
    mem_rdata <= mem[mem_addr];
    if (mem_we && halted) we_halted <= we_halted + 1;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  // every stored word carries junk in its upper nibble (R12)
  task automatic put(int a, logic [11:0] w);
    mem[a] = {4'hB, w};
  endtask

  task automatic fill();
    for (int i = 0; i < 4096; i++) mem[i] = {4'hB, 12'o0};
  endtask

  task automatic run(output int cyc);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("run timeout", 16'(cyc), 16'd0);
  endtask

  function automatic logic [12:0] g1_model(logic [11:0] a, logic l, logic [7:0] b);
    logic [12:0] v;
    v = {l, a};
    if (b[7]) v[11:0] = 12'o0;
    if (b[6]) v[12] = 1'b0;
    if (b[5]) v[11:0] = ~v[11:0];
    if (b[4]) v[12] = ~v[12];
    if (b[0]) v = v + 13'd1;
    for (int k = 0; k < (b[1] ? 2 : 1); k++) begin
      if (b[2])      v = {v[11:0], v[12]};
      else if (b[3]) v = {v[0], v[12:1]};
    end
    return v;
  endfunction

  logic [11:0] vals [5] = '{12'o0, 12'o1, 12'o7777, 12'o4000, 12'o2525};

  initial begin : main
    int cyc;
    logic [12:0] e;
    logic [11:0] pc_h, ac_h;

    // R1: reset state
    fill();
    put(0, 12'o7402);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc", 16'(pc_o), 0); chk("R1 ir", 16'(ir_o), 0);
    chk("R1 ac", 16'(ac_o), 0); chk("R1 link", 16'(link_o), 0);
    chk("R1 halted", 16'(halted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first fetch addr", 16'(pc_o), 0);

    // R4 timing and add: CLA CLL, three adds, halt -> 2+9+2 cycles
    fill();
    put(0, 12'o7300); put(1, 12'o1020); put(2, 12'o1020); put(3, 12'o1020);
    put(4, 12'o7402); put(8'o20, 12'o3001);
    run(cyc);
    chk("R4 direct add cycles", 16'(cyc), 13);
    chk("R4 add ac", 16'(ac_o), 16'(12'(3 * 12'o3001)));
    chk("R4 add link", 16'(link_o), 1);
    chk("R11 halt ir", 16'(ir_o), 16'(12'o7402));
    chk("R11 halt pc", 16'(pc_o), 5);
    // R11: frozen after halt
    pc_h = pc_o; ac_h = ac_o;
    repeat (6) @(negedge clk);
    chk("R11 pc held", 16'(pc_o), 16'(pc_h));
    chk("R11 ac held", 16'(ac_o), 16'(ac_h));
    chk("R11 still halted", 16'(halted), 1);
    chk("R11 no write halted", 16'(we_halted), 0);

    // R4: add and AND sweep
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int l = 0; l < 2; l++) begin
          put(0, 12'o7300); put(1, l ? 12'o7020 : 12'o7000);
          put(2, 12'o1020); put(3, 12'o1021); put(4, 12'o7402);
          put(8'o20, vals[i]); put(8'o21, vals[j]);
          run(cyc);
          e = {1'b0, vals[i]} + {1'b0, vals[j]};
          chk("R4 add sum", 16'(ac_o), 16'(e[11:0]));
          chk("R4 add carry link", 16'(link_o), 16'(l[0] ^ e[12]));
          put(2, 12'o1020); put(3, 12'o0021);
          run(cyc);
          chk("R4 and", 16'(ac_o), 16'(vals[i] & vals[j]));
        end

    // R2 R3 R6: paging, pointer, deposit
    fill();
    put(0, 12'o5410); put(8'o10, 12'o0200);
    put(12'o200, 12'o7300); put(12'o201, 12'o1030); put(12'o202, 12'o1250);
    put(12'o203, 12'o1411); put(12'o204, 12'o3251); put(12'o205, 12'o7402);
    put(8'o30, 12'o0003); put(12'o250, 12'o0040); put(8'o50, 12'o0777);
    put(8'o11, 12'o5000); put(12'o5000, 12'o0100); put(8'o100, 12'o2000);
    run(cyc);
    chk("R2 R3 R6 deposit value", mem[12'o251], 16'(12'o0143));
    chk("R6 ac cleared", 16'(ac_o), 0);
    chk("R3 pointer jump pc", 16'(pc_o), 16'(12'o206));

    // R5: increment-skip loop
    fill();
    put(0, 12'o2020); put(1, 12'o5000); put(2, 12'o7402); put(8'o20, 12'o7776);
    run(cyc);
    chk("R5 isz memory", mem[8'o20], 0);
    chk("R5 isz skip pc", 16'(pc_o), 3);
    fill();
    put(0, 12'o2020); put(1, 12'o7402); put(2, 12'o7402); put(8'o20, 12'o0005);
    run(cyc);
    chk("R5 isz no skip mem", mem[8'o20], 6);
    chk("R5 isz no skip pc", 16'(pc_o), 2);

    // R7: nested calls
    fill();
    put(0, 12'o4040); put(1, 12'o7402);
    put(8'o41, 12'o4060); put(8'o42, 12'o7001); put(8'o43, 12'o5440);
    put(8'o61, 12'o7001); put(8'o62, 12'o5460);
    run(cyc);
    chk("R7 outer return slot", mem[8'o40], 1);
    chk("R7 inner return slot", mem[8'o60], 16'(12'o42));
    chk("R7 ac", 16'(ac_o), 2);
    chk("R7 pc", 16'(pc_o), 2);

    // R12: I/O word is a no-op
    fill();
    put(0, 12'o6046); put(1, 12'o7001); put(2, 12'o7402);
    run(cyc);
    chk("R12 iot ac", 16'(ac_o), 1);
    chk("R12 iot pc", 16'(pc_o), 3);

    // R8 R9: group-1 exhaustive sweep
    for (int i = 0; i < 5; i++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 256; b++) begin
          put(0, 12'o7300); put(1, 12'o1020); put(2, l ? 12'o7020 : 12'o7000);
          put(3, 12'o7000 | 12'(b)); put(4, 12'o7402); put(8'o20, vals[i]);
          run(cyc);
          e = g1_model(vals[i], l[0], 8'(b));
          chk("R8 R9 group1 ac", 16'(ac_o), 16'(e[11:0]));
          chk("R8 R9 group1 link", 16'(link_o), 16'(e[12]));
        end

    // R10: group-2 sweep over bits 7..2
    for (int i = 0; i < 5; i++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 64; b++) begin
          logic cnd;
          logic [11:0] w;
          w = 12'o7400 | 12'(b << 2);
          put(0, 12'o7300); put(1, 12'o1020); put(2, l ? 12'o7020 : 12'o7000);
          put(3, w); put(4, 12'o7402); put(5, 12'o7402); put(8'o20, vals[i]);
          run(cyc);
          cnd = (w[6] && vals[i][11]) || (w[5] && vals[i] == 0) || (w[4] && l[0]);
          chk("R10 skip pc", 16'(pc_o), (cnd ^ w[3]) ? 6 : 5);
          chk("R10 ac", 16'(ac_o), w[7] ? 0 : 16'(vals[i]));
          chk("R10 link", 16'(link_o), 16'(l[0]));
        end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule